// File: doc/BRIEF.md
# Instruction Group Dependency Checker

This block watches a stream of decoded instruction slots, one per cycle, and finds where instruction groups begin and end. Each slot may read up to two registers and write one. Inside a group every read counts as happening before every write in that group, so a read of a register that an earlier slot in the same group wrote is an ordering violation. Two writes to the same register in one group are also reported. At a group boundary all earlier writes count as complete, and the tracking starts again from empty.

A group is closed only by a stop, a taken branch, a break fault raised by a branch-unit break, or an illegal-operation fault from a reserved branch-space encoding. Other control-flow events, such as breaks on the other units, check instructions, a return-from-interruption or long branch with no stop, and other interruptions, leave the group open. Slots after such an event still belong to the same group and are still checked. All outputs are registered and show the effect of a slot in the cycle after it is presented.

Top module: `igroup_dep_check`

## Requirements
- R1: A valid slot with `stopAfter`=1, or with `eventCode` 1 (taken branch), 2 (branch-unit break fault) or 3 (reserved branch encoding fault), ends the group. `groupEnd` is high for exactly the cycle after that slot, and `groupSeq` goes up by one in that same cycle.
- R2: `eventCode` values 4 (break on another unit), 5 (check instruction), 6 (return-from-interruption or long branch) and 7 (other interruption) do not end the group when `stopAfter`=0. The slots that follow stay in the same group and are still checked.
- R3: A valid slot with an enabled source (`srcAEn` or `srcBEn`) naming a register that an earlier slot in the same group wrote raises `violation`.
- R4: A slot that reads and writes the same register is not a violation by itself.
- R5: A valid slot with `dstEn`=1 whose destination was already written earlier in the same group raises `violation`.
- R6: Writes from a finished group cause no violation in any later group.
- R7: `violSlot` gives the position in the group, counted from 0, of the first offending slot. `violation` and `violSlot` keep that value through the end of the group and change only when the next group's first slot is taken.
- R8: A slot with `slotValid`=0 changes no state and no output. This covers the write tracking, the slot position, the group boundary and the counters.
- R9: While `rst` is high at a clock edge, all state is cleared: `groupEnd`=0, `violation`=0, `violSlot`=0, `groupSeq`=0, and the next valid slot starts a new group with no writes tracked.
- R10: The slot position counter saturates at 2^SLOT_W-1, so a violation late in a long group reports that value.
- R11: `groupSeq` counts completed groups modulo 2^SEQ_W.
- R12: A source or destination index is ignored when its enable bit is 0. The slot that ends a group is itself part of that group and is checked against it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slotValid | input | 1 | A slot is presented this cycle |
| srcAEn | input | 1 | First source is used |
| srcA | input | $clog2(NUM_REGS) | First source register index |
| srcBEn | input | 1 | Second source is used |
| srcB | input | $clog2(NUM_REGS) | Second source register index |
| dstEn | input | 1 | Destination is written |
| dst | input | $clog2(NUM_REGS) | Destination register index |
| stopAfter | input | 1 | A stop follows this slot |
| eventCode | input | 3 | Decoded control event of the slot (see R1, R2) |
| groupEnd | output | 1 | One-cycle pulse after a group-ending slot |
| violation | output | 1 | Dependency violation seen in the current or just-ended group |
| violSlot | output | SLOT_W | Position of the first offending slot |
| groupSeq | output | SEQ_W | Completed group count |

## Verification
The bench uses NUM_REGS=128 and keeps the full register index range. It sets SLOT_W=3, so a group of ten slots drives the position counter into saturation. It sets SEQ_W=4, so sixteen group endings wrap the sequence counter back to zero within a short directed run. The vector table goes through every event code, with and without a stop, and through both source ports. It also covers a slot that reads and writes the same register, an invalid slot placed between related slots, and a reset in the middle of a group.

// File: rtl/igroup_pkg.sv
package igroup_pkg;

  typedef enum logic [2:0] {
    EV_NONE       = 3'd0,
    EV_TAKEN      = 3'd1,
    EV_BRK_BRANCH = 3'd2,
    EV_RSV_BRANCH = 3'd3,
    EV_BRK_OTHER  = 3'd4,
    EV_CHECK      = 3'd5,
    EV_RFI_LONG   = 3'd6,
    EV_INTR       = 3'd7
  } slotEvent_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic take;      // a valid slot is accepted this cycle
    logic openGrp;   // this slot is the first of a group
    logic closeGrp;  // this slot ends its group
  } grpStrobe_t;

endpackage

// File: rtl/igroup_ctrl.sv
module igroup_ctrl
  import igroup_pkg::*;
#(
  parameter int SLOT_W = 4,
  parameter int SEQ_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slotValid,
  input  logic              stopAfter,
  input  logic [2:0]        eventCode,
  output grpStrobe_t        stb,
  output logic [SLOT_W-1:0] slotIdx,
  output logic [SEQ_W-1:0]  groupSeq,
  output logic              groupEnd
);

  localparam logic [SLOT_W-1:0] SLOT_MAX = {SLOT_W{1'b1}};

  slotEvent_e evKind;
  logic       closes;
  logic       freshQ;
  logic [SLOT_W-1:0] slotIdxQ;
  logic [SEQ_W-1:0]  groupSeqQ;
  logic              groupEndQ;

  assign evKind = slotEvent_e'(eventCode);

  always_comb begin
    unique case (evKind)
      EV_TAKEN, EV_BRK_BRANCH, EV_RSV_BRANCH: closes = 1'b1;
      default:                                closes = stopAfter;
    endcase
  end

  assign stb.take     = slotValid;
  assign stb.openGrp  = freshQ;
  assign stb.closeGrp = slotValid & closes;

  always_ff @(posedge clk) begin
    if (rst) begin
      freshQ    <= 1'b1;
      slotIdxQ  <= '0;
      groupSeqQ <= '0;
      groupEndQ <= 1'b0;
    end else begin
      groupEndQ <= stb.closeGrp;
      if (slotValid) begin
        freshQ <= closes;
        if (closes) begin
          slotIdxQ  <= '0;
          groupSeqQ <= groupSeqQ + 1'b1;
        end else if (slotIdxQ != SLOT_MAX) begin
          slotIdxQ <= slotIdxQ + 1'b1;
        end
      end
    end
  end

  assign slotIdx  = slotIdxQ;
  assign groupSeq = groupSeqQ;
  assign groupEnd = groupEndQ;

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && groupEndQ) |-> groupSeqQ == $past(groupSeqQ) + 1'b1); // R1
  AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !groupEndQ) |-> $stable(groupSeqQ)); // R11
  AST_NEW_GROUP_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    groupEndQ |-> (slotIdxQ == '0 && freshQ)); // R1
  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(slotValid)) |-> ($stable(slotIdxQ) && !groupEndQ)); // R8

endmodule

// File: rtl/igroup_datapath.sv
module igroup_datapath
  import igroup_pkg::*;
#(
  parameter int NUM_REGS = 128,
  parameter int SLOT_W   = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  grpStrobe_t        stb,
  input  logic [SLOT_W-1:0] slotIdx,
  input  logic              srcAEn,
  input  logic [IDX_W-1:0]  srcA,
  input  logic              srcBEn,
  input  logic [IDX_W-1:0]  srcB,
  input  logic              dstEn,
  input  logic [IDX_W-1:0]  dst,
  output logic              violation,
  output logic [SLOT_W-1:0] violSlot
);

  logic [NUM_REGS-1:0] writtenQ;
  logic [NUM_REGS-1:0] setMask;
  logic [NUM_REGS-1:0] writtenNext;
  logic readHit, writeHit, slotHit;
  logic violQ;
  logic [SLOT_W-1:0] violSlotQ;

  // One decoded set bit per register
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_mask
    assign setMask[r] = dstEn && (dst == IDX_W'(r));
  end

  assign readHit  = (srcAEn && writtenQ[srcA]) || (srcBEn && writtenQ[srcB]);
  assign writeHit = dstEn && writtenQ[dst];
  assign slotHit  = readHit || writeHit;

  always_comb begin
    writtenNext = writtenQ;
    if (stb.take) begin
      if (stb.closeGrp) writtenNext = '0;
      else              writtenNext = writtenQ | setMask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      writtenQ  <= '0;
      violQ     <= 1'b0;
      violSlotQ <= '0;
    end else begin
      writtenQ <= writtenNext;
      if (stb.take) begin
        if (stb.openGrp) begin
          violQ     <= slotHit;
          violSlotQ <= slotHit ? slotIdx : '0;
        end else if (!violQ && slotHit) begin
          violQ     <= 1'b1;
          violSlotQ <= slotIdx;
        end
      end
    end
  end

  assign violation = violQ;
  assign violSlot  = violSlotQ;

  AST_EMPTY_AT_OPEN: assert property (@(posedge clk) disable iff (rst)
    stb.openGrp |-> writtenQ == '0); // R6
  AST_IDLE_KEEPS_MAP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(stb.take)) |-> $stable(writtenQ)); // R8
  AST_VIOL_HELD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(violQ) && !$past(stb.openGrp)) |-> (violQ && $stable(violSlotQ))); // R7
  AST_FIRST_SLOT_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (stb.take && stb.openGrp) |-> !slotHit); // R6

endmodule

// File: rtl/igroup_dep_check.sv
module igroup_dep_check
  import igroup_pkg::*;
#(
  parameter int NUM_REGS = 128,
  parameter int SLOT_W   = 4,
  parameter int SEQ_W    = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slotValid,
  input  logic              srcAEn,
  input  logic [IDX_W-1:0]  srcA,
  input  logic              srcBEn,
  input  logic [IDX_W-1:0]  srcB,
  input  logic              dstEn,
  input  logic [IDX_W-1:0]  dst,
  input  logic              stopAfter,
  input  logic [2:0]        eventCode,
  output logic              groupEnd,
  output logic              violation,
  output logic [SLOT_W-1:0] violSlot,
  output logic [SEQ_W-1:0]  groupSeq
);

  grpStrobe_t        stb;
  logic [SLOT_W-1:0] slotIdx;

  igroup_ctrl #(.SLOT_W(SLOT_W), .SEQ_W(SEQ_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .slotValid (slotValid),
    .stopAfter (stopAfter),
    .eventCode (eventCode),
    .stb       (stb),
    .slotIdx   (slotIdx),
    .groupSeq  (groupSeq),
    .groupEnd  (groupEnd)
  );

  igroup_datapath #(.NUM_REGS(NUM_REGS), .SLOT_W(SLOT_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .slotIdx   (slotIdx),
    .srcAEn    (srcAEn),
    .srcA      (srcA),
    .srcBEn    (srcBEn),
    .srcB      (srcB),
    .dstEn     (dstEn),
    .dst       (dst),
    .violation (violation),
    .violSlot  (violSlot)
  );

endmodule

// File: tb/igroup_dep_check_bench.sv
module igroup_dep_check_bench;
  localparam int NREG = 128;
  localparam int SW   = 3;
  localparam int QW   = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, slotValid, srcAEn, srcBEn, dstEn, stopAfter;
  logic [6:0] srcA, srcB, dst;
  logic [2:0] eventCode;
  logic groupEnd, violation;
  logic [SW-1:0] violSlot;
  logic [QW-1:0] groupSeq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  igroup_dep_check #(.NUM_REGS(NREG), .SLOT_W(SW), .SEQ_W(QW)) u_igroup_dep_check (
    .clk(clk), .rst(rst), .slotValid(slotValid),
    .srcAEn(srcAEn), .srcA(srcA), .srcBEn(srcBEn), .srcB(srcB),
    .dstEn(dstEn), .dst(dst), .stopAfter(stopAfter), .eventCode(eventCode),
    .groupEnd(groupEnd), .violation(violation), .violSlot(violSlot), .groupSeq(groupSeq)
  );

  typedef struct packed {
    logic v; logic aE; logic [6:0] a; logic bE; logic [6:0] b;
    logic dE; logic [6:0] d; logic st; logic [2:0] ev;
    logic xE; logic xV; logic [SW-1:0] xS; logic [QW-1:0] xQ;
    logic [3:0] req;
  } vec_t;

  // v aE a bE b dE d st ev | groupEnd viol violSlot seq | requirement
  localparam vec_t TBL [21] = '{
    '{1,0,0, 0,0, 1,5, 0,0,  0,0,0,0, 3},  // write r5
    '{1,1,5, 0,0, 0,0, 0,0,  0,1,1,0, 3},  // R3 read r5 -> slot 1
    '{1,0,0, 0,0, 1,6, 0,4,  0,1,1,0, 2},  // R2 other-unit break keeps group
    '{1,1,6, 0,0, 0,0, 0,5,  0,1,1,0, 7},  // R7 second offence, first held
    '{1,0,0, 0,0, 0,0, 1,0,  1,1,1,1, 1},  // R1 stop ends group
    '{1,1,5, 1,6, 1,5, 0,0,  0,0,0,1, 6},  // R6 new group clean
    '{1,0,0, 0,0, 1,5, 0,0,  0,1,1,1, 5},  // R5 write-after-write
    '{1,0,0, 0,0, 0,0, 0,1,  1,1,1,2, 1},  // R1 taken branch
    '{1,1,7, 0,0, 1,7, 0,0,  0,0,0,2, 4},  // R4 read+write same reg
    '{1,0,0, 0,0, 1,9, 0,6,  0,0,0,2, 2},  // R2 rfi/long branch no stop
    '{1,0,0, 1,9, 0,0, 0,7,  0,1,2,2, 2},  // R2 interruption keeps group, B read hit
    '{1,0,0, 0,0, 0,0, 0,2,  1,1,2,3, 1},  // R1 branch-unit break fault
    '{1,0,0, 0,0, 1,10,0,3,  1,0,0,4, 1},  // R1 reserved-encoding fault
    '{1,1,10,0,0, 0,0, 1,6,  1,0,0,5, 1},  // R1 rfi with stop ends, R6 clean
    '{1,0,0, 0,0, 1,20,0,0,  0,0,0,5, 3},  // write r20
    '{0,1,20,1,20,1,20,1,1,  0,0,0,5, 8},  // R8 invalid slot ignored
    '{1,0,20,0,0, 0,0, 0,0,  0,0,0,5,12},  // R12 disabled source ignored
    '{1,0,0, 1,20,0,0, 0,0,  0,1,2,5, 8},  // R8 position not advanced by invalid
    '{1,1,20,0,0, 0,0, 1,0,  1,1,2,6, 7},  // R7 held through end
    '{1,0,0, 0,0, 1,3, 0,0,  0,0,0,6, 7},  // R7 cleared by next group first slot
    '{1,1,3, 0,0, 0,0, 1,0,  1,1,1,7,12}   // R12 ending slot itself checked
  };

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  task automatic drive(input logic v, input logic aE, input int a, input logic bE, input int b,
                       input logic dE, input int d, input logic st, input int ev);
    @(negedge clk);
    slotValid = v; srcAEn = aE; srcA = 7'(a); srcBEn = bE; srcB = 7'(b);
    dstEn = dE; dst = 7'(d); stopAfter = st; eventCode = 3'(ev);
    @(posedge clk);
    #1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    rst = 1; slotValid = 0; srcAEn = 0; srcA = 0; srcBEn = 0; srcB = 0;
    dstEn = 0; dst = 0; stopAfter = 0; eventCode = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R9", "groupEnd", groupEnd, 0);
    check("R9", "violation", violation, 0);
    check("R9", "groupSeq", groupSeq, 0);
    @(negedge clk) rst = 0;

    for (int i = 0; i < 21; i++) begin
      string tag;
      tag = $sformatf("R%0d row%0d", TBL[i].req, i);
      drive(TBL[i].v, TBL[i].aE, TBL[i].a, TBL[i].bE, TBL[i].b,
            TBL[i].dE, TBL[i].d, TBL[i].st, TBL[i].ev);
      check(tag, "groupEnd", groupEnd, TBL[i].xE);
      check(tag, "violation", violation, TBL[i].xV);
      check(tag, "violSlot", violSlot, TBL[i].xS);
      check(tag, "groupSeq", groupSeq, TBL[i].xQ);
    end

    // R9: reset in the middle of a group
    drive(1, 0, 0, 0, 0, 1, 8, 0, 0);
    @(negedge clk); rst = 1; slotValid = 0;
    @(posedge clk); #1;
    check("R9", "groupEnd", groupEnd, 0);
    check("R9", "violation", violation, 0);
    check("R9", "groupSeq", groupSeq, 0);
    @(negedge clk); rst = 0;
    drive(1, 1, 8, 0, 0, 1, 8, 1, 0);
    check("R9", "violation after reset", violation, 0);
    check("R9", "groupSeq after reset", groupSeq, 1);

    // R10: long group saturates slot position
    for (int i = 0; i < 10; i++) drive(1, 0, 0, 0, 0, 1, 30 + i, 0, 0);
    check("R10", "no violation yet", violation, 0);
    drive(1, 1, 30, 0, 0, 0, 0, 0, 0);
    check("R10", "violation", violation, 1);
    check("R10", "violSlot saturated", violSlot, 7);
    drive(1, 0, 0, 0, 0, 0, 0, 1, 0);
    check("R10", "groupSeq", groupSeq, 2);

    // R11: sequence counter wraps
    for (int i = 0; i < 13; i++) drive(1, 0, 0, 0, 0, 0, 0, 1, 0);
    check("R11", "groupSeq before wrap", groupSeq, 15);
    drive(1, 0, 0, 0, 0, 0, 0, 1, 0);
    check("R11", "groupSeq wrapped", groupSeq, 0);
    check("R11", "groupEnd", groupEnd, 1);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R1", "pulse single cycle", groupEnd, 0);

    finishRun();
  end
endmodule